// File: doc/BRIEF.md
# Page Recoloring Remap Unit

This unit spreads virtual pages more evenly across the colors of a shared cache. Every cache color forms one region. For each region the unit watches the stream of accesses and keeps a small frequency estimate of the two virtual pages that use that region most. A classifier elsewhere decides which regions are overloaded (hot) and which are underused (cold). It then raises a start strobe with the two label vectors. The unit walks the hot regions. In each hot region it keeps the page with the higher count where it is, and it sends the other page to a cold region by writing a new color for that page into a small remap table.

The table sits in the address translation path. A later lookup of a moved page returns its new color, and any other page keeps the color it came with. No page data is copied. A pass takes one cycle per hot region that it visits. It ends when it runs out of hot regions or cold regions, reaches its move budget, or fills the table.

The access input is a valid/ready stream. `acc_ready` is high whenever no pass is running, and an access counts only in a cycle where both `acc_valid` and `acc_ready` are high. While a pass runs, `acc_ready` is low and the producer has to hold or drop its traffic. Lookups have no back-pressure. Every request is accepted, and its answer appears exactly one cycle later.

Top module: `prc_recolor_unit`

## Requirements
- R1: `acc_ready` is 1 when the unit is idle and 0 while a pass runs. An access updates tracking only in a cycle where both `acc_valid` and `acc_ready` are 1.
- R2: Each region has two tracking slots, 0 and 1, each holding a page and a count. The cases are applied in the order listed:
  - If the page matches a valid slot, that slot's count increases and saturates at 2^CNT_W-1.
  - Otherwise, if a slot is empty, the page fills the lowest-numbered empty slot with count 1.
  - Otherwise the victim is the slot with the lower count, or slot 1 on a tie. If the victim's count is 0, the page replaces it with count 1; if not, the victim's count drops by 1.
- R3: A start strobe seen while idle latches the hot vector, and latches the cold vector with every hot bit cleared. `busy` is 1 from the next cycle on. A start seen while busy is ignored.
- R4: Each cycle of a pass takes the lowest-indexed hot region h and the lowest-indexed cold region c. If region h tracks two pages, the page that stays is the one with the higher count (slot 0 on a tie). The other page gets color c, is dropped from h's slots, and cold bit c is cleared. Hot bit h is cleared in either case.
- R5: A pass stops in the first cycle that finds any of these: no hot bit set, no cold bit set, MAX_MOVES pages moved, or every table slot in use. In the cycle after that, `done` is 1 for exactly one cycle and `busy` is 0.
- R6: A table write to a page that already has an entry overwrites that entry's color. Otherwise the write goes into the lowest-numbered free slot. Entries are never freed except by reset.
- R7: A lookup request gives `rsp_valid` = 1 one cycle later. `rsp_color` is the page's table color on a hit, or the request's `lk_color` on a miss.
- R8: A lookup in the same cycle as a table write returns the mapping as it stood before that write.
- R9: After reset the tracking slots and the table are empty, `busy`, `done` and `rsp_valid` are 0, and `acc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access stream valid |
| acc_ready | output | 1 | Access stream ready |
| acc_vpn | input | VPN_W | Virtual page of the access |
| acc_region | input | $clog2(NREG) | Cache region (color) of the access |
| start | input | 1 | Start a recoloring pass |
| hot_mask | input | NREG | Hot region labels |
| cold_mask | input | NREG | Cold region labels |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at pass end |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_color | input | $clog2(NREG) | Original color of the page |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_color | output | $clog2(NREG) | Translated color |

## Verification
The bench builds the unit with 8 regions, 12-bit pages, 2-bit counters, a 4-entry table and a budget of 3 moves. With counters this narrow, saturation and the decrement-then-replace path of the tracking slots take only a handful of accesses. With this table depth and budget, the table-full stop and the budget stop each fall within a short pass, and they can be told apart from the stops for running out of hot or cold regions. The overwrite of an existing entry also becomes reachable. Lookups are held active through every pass, so the cycle in which a table write lands also carries a lookup.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_t;
endpackage

// File: rtl/prc_tracker.sv
// Per-region top-two frequent page estimator.
module prc_tracker #(
  parameter int NREG   = 16,
  parameter int VPN_W  = 20,
  parameter int CNT_W  = 4,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  upd_en,
  input  logic [VPN_W-1:0]                      upd_vpn,
  input  logic [RIDX_W-1:0]                     upd_region,
  input  logic                                  inv_en,
  input  logic [RIDX_W-1:0]                     inv_region,
  input  logic                                  inv_slot,
  output logic [NREG-1:0][1:0]                  trk_vld,
  output logic [NREG-1:0][1:0][VPN_W-1:0]       trk_vpn,
  output logic [NREG-1:0][1:0][CNT_W-1:0]       trk_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [1:0]             vld_q, vld_d;
    logic [1:0][VPN_W-1:0]  vpn_q, vpn_d;
    logic [1:0][CNT_W-1:0]  cnt_q, cnt_d;
    logic                   hit0, hit1, victim, mine;

    always_comb begin
      vld_d  = vld_q;
      vpn_d  = vpn_q;
      cnt_d  = cnt_q;
      hit0   = vld_q[0] && (vpn_q[0] == upd_vpn);
      hit1   = vld_q[1] && (vpn_q[1] == upd_vpn);
      victim = (cnt_q[1] <= cnt_q[0]);
      mine   = upd_en && (upd_region == RIDX_W'(r));
      if (inv_en && (inv_region == RIDX_W'(r))) begin
        vld_d[inv_slot] = 1'b0;
      end else if (mine) begin
        if (hit0) begin
          if (cnt_q[0] != CNT_MAX) cnt_d[0] = cnt_q[0] + CNT_ONE;
        end else if (hit1) begin
          if (cnt_q[1] != CNT_MAX) cnt_d[1] = cnt_q[1] + CNT_ONE;
        end else if (!vld_q[0]) begin
          vld_d[0] = 1'b1;
          vpn_d[0] = upd_vpn;
          cnt_d[0] = CNT_ONE;
        end else if (!vld_q[1]) begin
          vld_d[1] = 1'b1;
          vpn_d[1] = upd_vpn;
          cnt_d[1] = CNT_ONE;
        end else if (cnt_q[victim] == '0) begin
          vpn_d[victim] = upd_vpn;
          cnt_d[victim] = CNT_ONE;
        end else begin
          cnt_d[victim] = cnt_q[victim] - CNT_ONE;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        vpn_q <= '0;
        cnt_q <= '0;
      end else begin
        vld_q <= vld_d;
        vpn_q <= vpn_d;
        cnt_q <= cnt_d;
      end
    end

    assign trk_vld[r] = vld_q;
    assign trk_vpn[r] = vpn_q;
    assign trk_cnt[r] = cnt_q;
  end
endmodule

// File: rtl/prc_remap_table.sv
// Fully associative page-to-color table with a registered lookup port.
module prc_remap_table #(
  parameter int DEPTH   = 16,
  parameter int VPN_W   = 20,
  parameter int COLOR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [COLOR_W-1:0] wr_color,
  input  logic               lk_valid,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [COLOR_W-1:0] lk_color,
  output logic               full,
  output logic [DEPTH-1:0]   used,
  output logic               rsp_valid,
  output logic [COLOR_W-1:0] rsp_color
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][VPN_W-1:0]   ent_vpn;
  logic [DEPTH-1:0][COLOR_W-1:0] ent_col;
  logic [DEPTH-1:0]              wr_hit;
  logic [IDX_W-1:0]              free_idx;
  logic                          free_any;
  logic [COLOR_W-1:0]            rsp_d;
  logic                          rsp_valid_q;
  logic [COLOR_W-1:0]            rsp_color_q;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      wr_hit[i] = used[i] && (ent_vpn[i] == wr_vpn);
      if (!used[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic               v_q;
    logic [VPN_W-1:0]   p_q;
    logic [COLOR_W-1:0] c_q;
    logic               sel;

    assign sel = wr_hit[i] || (!(|wr_hit) && free_any && (free_idx == IDX_W'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
        c_q <= '0;
      end else if (wr_en && sel) begin
        v_q <= 1'b1;
        p_q <= wr_vpn;
        c_q <= wr_color;
      end
    end

    assign used[i]    = v_q;
    assign ent_vpn[i] = p_q;
    assign ent_col[i] = c_q;
  end

  assign full = &used;

  always_comb begin
    rsp_d = lk_color;
    for (int i = 0; i < DEPTH; i++) begin
      if (used[i] && (ent_vpn[i] == lk_vpn)) rsp_d = ent_col[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_color_q <= '0;
    end else begin
      rsp_valid_q <= lk_valid;
      if (lk_valid) rsp_color_q <= rsp_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_color = rsp_color_q;
endmodule

// File: rtl/prc_sequencer.sv
// Recoloring pass controller: one hot region per cycle.
module prc_sequencer
  import prc_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int VPN_W     = 20,
  parameter int CNT_W     = 4,
  parameter int MAX_MOVES = 8,
  parameter int RIDX_W    = $clog2(NREG),
  parameter int MV_W      = $clog2(MAX_MOVES + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [NREG-1:0]                  hot_in,
  input  logic [NREG-1:0]                  cold_in,
  input  logic [NREG-1:0][1:0]             trk_vld,
  input  logic [NREG-1:0][1:0][VPN_W-1:0]  trk_vpn,
  input  logic [NREG-1:0][1:0][CNT_W-1:0]  trk_cnt,
  input  logic                             tbl_full,
  output logic                             busy,
  output logic                             done,
  output logic                             tbl_wr,
  output logic [VPN_W-1:0]                 tbl_vpn,
  output logic [RIDX_W-1:0]                tbl_color,
  output logic                             inv_en,
  output logic [RIDX_W-1:0]                inv_region,
  output logic                             inv_slot,
  output logic [MV_W-1:0]                  move_cnt
);
  seq_state_t        state_q;
  logic [NREG-1:0]   hot_q, cold_q;
  logic [MV_W-1:0]   moves_q;
  logic              done_q;
  logic [RIDX_W-1:0] h_idx, c_idx;
  logic              h_any, c_any, pair, slot, stop, step;

  always_comb begin
    h_idx = '0;
    c_idx = '0;
    h_any = 1'b0;
    c_any = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hot_q[i]) begin
        h_any = 1'b1;
        h_idx = RIDX_W'(i);
      end
      if (cold_q[i]) begin
        c_any = 1'b1;
        c_idx = RIDX_W'(i);
      end
    end
  end

  assign pair = &trk_vld[h_idx];
  assign slot = (trk_cnt[h_idx][1] <= trk_cnt[h_idx][0]);
  assign stop = !h_any || !c_any || (moves_q == MV_W'(MAX_MOVES)) || tbl_full;
  assign step = (state_q == SEQ_SCAN) && !stop;

  assign tbl_wr     = step && pair;
  assign tbl_vpn    = trk_vpn[h_idx][slot];
  assign tbl_color  = c_idx;
  assign inv_en     = step && pair;
  assign inv_region = h_idx;
  assign inv_slot   = slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      hot_q   <= '0;
      cold_q  <= '0;
      moves_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == SEQ_IDLE) begin
        if (start) begin
          hot_q   <= hot_in;
          cold_q  <= cold_in & ~hot_in;
          moves_q <= '0;
          state_q <= SEQ_SCAN;
        end
      end else if (stop) begin
        state_q <= SEQ_IDLE;
        done_q  <= 1'b1;
      end else begin
        hot_q[h_idx] <= 1'b0;
        if (pair) begin
          cold_q[c_idx] <= 1'b0;
          moves_q       <= moves_q + MV_W'(1);
        end
      end
    end
  end

  assign busy     = (state_q == SEQ_SCAN);
  assign done     = done_q;
  assign move_cnt = moves_q;
endmodule

// File: rtl/prc_recolor_unit.sv
module prc_recolor_unit #(
  parameter int NREG      = 16,
  parameter int VPN_W     = 20,
  parameter int CNT_W     = 4,
  parameter int MAP_DEPTH = 16,
  parameter int MAX_MOVES = 8,
  localparam int RIDX_W   = $clog2(NREG),
  localparam int MV_W     = $clog2(MAX_MOVES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [VPN_W-1:0]  acc_vpn,
  input  logic [RIDX_W-1:0] acc_region,
  input  logic              start,
  input  logic [NREG-1:0]   hot_mask,
  input  logic [NREG-1:0]   cold_mask,
  output logic              busy,
  output logic              done,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [RIDX_W-1:0] lk_color,
  output logic              rsp_valid,
  output logic [RIDX_W-1:0] rsp_color
);
  logic [NREG-1:0][1:0]            trk_vld;
  logic [NREG-1:0][1:0][VPN_W-1:0] trk_vpn;
  logic [NREG-1:0][1:0][CNT_W-1:0] trk_cnt;
  logic                            tbl_wr, tbl_full, inv_en, inv_slot;
  logic [VPN_W-1:0]                tbl_vpn;
  logic [RIDX_W-1:0]               tbl_color, inv_region;
  logic [MAP_DEPTH-1:0]            tbl_used;
  logic [MV_W-1:0]                 move_cnt;

  assign acc_ready = !busy;

  prc_tracker #(
    .NREG(NREG), .VPN_W(VPN_W), .CNT_W(CNT_W), .RIDX_W(RIDX_W)
  ) u_trk (
    .clk(clk), .rst_n(rst_n),
    .upd_en(acc_valid && acc_ready), .upd_vpn(acc_vpn), .upd_region(acc_region),
    .inv_en(inv_en), .inv_region(inv_region), .inv_slot(inv_slot),
    .trk_vld(trk_vld), .trk_vpn(trk_vpn), .trk_cnt(trk_cnt)
  );

  prc_sequencer #(
    .NREG(NREG), .VPN_W(VPN_W), .CNT_W(CNT_W), .MAX_MOVES(MAX_MOVES),
    .RIDX_W(RIDX_W), .MV_W(MV_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .hot_in(hot_mask), .cold_in(cold_mask),
    .trk_vld(trk_vld), .trk_vpn(trk_vpn), .trk_cnt(trk_cnt),
    .tbl_full(tbl_full), .busy(busy), .done(done),
    .tbl_wr(tbl_wr), .tbl_vpn(tbl_vpn), .tbl_color(tbl_color),
    .inv_en(inv_en), .inv_region(inv_region), .inv_slot(inv_slot),
    .move_cnt(move_cnt)
  );

  prc_remap_table #(
    .DEPTH(MAP_DEPTH), .VPN_W(VPN_W), .COLOR_W(RIDX_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_vpn(tbl_vpn), .wr_color(tbl_color),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_color(lk_color),
    .full(tbl_full), .used(tbl_used),
    .rsp_valid(rsp_valid), .rsp_color(rsp_color)
  );
endmodule

// File: rtl/prc_recolor_checker.sv
module prc_recolor_checker #(
  parameter int MAP_DEPTH = 16,
  parameter int MAX_MOVES = 8,
  parameter int MV_W      = $clog2(MAX_MOVES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 lk_valid,
  input logic                 rsp_valid,
  input logic                 tbl_wr,
  input logic [MAP_DEPTH-1:0] tbl_used,
  input logic [MV_W-1:0]      move_cnt
);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_write_in_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |-> busy);

  assert_done_ends_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    move_cnt <= MV_W'(MAX_MOVES));

  assert_table_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tbl_used) >= $countones($past(tbl_used)));

  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_no_stray_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
endmodule

bind prc_recolor_unit prc_recolor_checker #(
  .MAP_DEPTH(MAP_DEPTH), .MAX_MOVES(MAX_MOVES), .MV_W(MV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .lk_valid(lk_valid), .rsp_valid(rsp_valid), .tbl_wr(tbl_wr),
  .tbl_used(tbl_used), .move_cnt(move_cnt)
);

// File: tb/test_prc_recolor_unit.sv
`timescale 1ns/1ps
module test_prc_recolor_unit;
  localparam int NREG = 8, VPN_W = 12, CNT_W = 2, DEPTH = 4, MAXMV = 3;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, start = 1'b0, lk_valid = 1'b0;
  logic acc_ready, busy, done, rsp_valid;
  logic [VPN_W-1:0] acc_vpn = '0, lk_vpn = '0;
  logic [2:0] acc_region = '0, lk_color = '0, rsp_color;
  logic [NREG-1:0] hot_mask = '0, cold_mask = '0;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prc_recolor_unit #(.NREG(NREG), .VPN_W(VPN_W), .CNT_W(CNT_W),
                     .MAP_DEPTH(DEPTH), .MAX_MOVES(MAXMV)) i_prc_recolor_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_vpn(acc_vpn), .acc_region(acc_region), .start(start),
    .hot_mask(hot_mask), .cold_mask(cold_mask), .busy(busy), .done(done),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_color(lk_color),
    .rsp_valid(rsp_valid), .rsp_color(rsp_color));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_tv[NREG][2];
  int m_tp[NREG][2];
  int m_tc[NREG][2];
  bit m_bv[DEPTH];
  int m_bp[DEPTH];
  int m_bc[DEPTH];
  bit m_busy, m_done, m_rv;
  int m_rc, m_moves;
  bit [NREG-1:0] m_hot, m_cold;

  task automatic m_reset();
    for (int r = 0; r < NREG; r++)
      for (int s = 0; s < 2; s++) begin m_tv[r][s] = 0; m_tp[r][s] = 0; m_tc[r][s] = 0; end
    for (int d = 0; d < DEPTH; d++) begin m_bv[d] = 0; m_bp[d] = 0; m_bc[d] = 0; end
    m_busy = 0; m_done = 0; m_rv = 0; m_rc = 0; m_moves = 0; m_hot = '0; m_cold = '0;
  endtask

  task automatic m_track(int v, int r);
    int vs;
    if (m_tv[r][0] && m_tp[r][0] == v) begin
      if (m_tc[r][0] < CMAX) m_tc[r][0]++;
    end else if (m_tv[r][1] && m_tp[r][1] == v) begin
      if (m_tc[r][1] < CMAX) m_tc[r][1]++;
    end else if (!m_tv[r][0]) begin
      m_tv[r][0] = 1; m_tp[r][0] = v; m_tc[r][0] = 1;
    end else if (!m_tv[r][1]) begin
      m_tv[r][1] = 1; m_tp[r][1] = v; m_tc[r][1] = 1;
    end else begin
      vs = (m_tc[r][1] <= m_tc[r][0]) ? 1 : 0;
      if (m_tc[r][vs] == 0) begin m_tp[r][vs] = v; m_tc[r][vs] = 1; end
      else m_tc[r][vs]--;
    end
  endtask

  task automatic m_step();
    int h, c, s, slot_w;
    bit full;
    h = -1; c = -1; full = 1;
    for (int d = 0; d < DEPTH; d++) if (!m_bv[d]) full = 0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (m_hot[i]) h = i;
      if (m_cold[i]) c = i;
    end
    if (h < 0 || c < 0 || m_moves == MAXMV || full) begin
      m_busy = 0; m_done = 1;
    end else begin
      if (m_tv[h][0] && m_tv[h][1]) begin
        s = (m_tc[h][1] <= m_tc[h][0]) ? 1 : 0;
        slot_w = -1;
        for (int d = 0; d < DEPTH; d++) if (m_bv[d] && m_bp[d] == m_tp[h][s]) slot_w = d;
        if (slot_w < 0)
          for (int d = DEPTH - 1; d >= 0; d--) if (!m_bv[d]) slot_w = d;
        m_bv[slot_w] = 1; m_bp[slot_w] = m_tp[h][s]; m_bc[slot_w] = c;
        m_tv[h][s] = 0;
        m_cold[c] = 0;
        m_moves++;
      end
      m_hot[h] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      m_rv = lk_valid;
      if (lk_valid) begin
        m_rc = int'(lk_color);
        for (int d = 0; d < DEPTH; d++) if (m_bv[d] && m_bp[d] == int'(lk_vpn)) m_rc = m_bc[d];
      end
      m_done = 0;
      if (!m_busy) begin
        if (acc_valid) m_track(int'(acc_vpn), int'(acc_region));
        if (start) begin
          m_hot = hot_mask; m_cold = cold_mask & ~hot_mask; m_moves = 0; m_busy = 1;
        end
      end else m_step();
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 acc_ready", int'(acc_ready), m_busy ? 0 : 1);
      chk("R3 R5 busy", int'(busy), int'(m_busy));
      chk("R5 done", int'(done), int'(m_done));
      chk("R7 rsp_valid", int'(rsp_valid), int'(m_rv));
      if (m_rv) chk("R7 R8 rsp_color", int'(rsp_color), m_rc);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(int v, int r, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      acc_valid = 1'b1; acc_vpn = VPN_W'(v); acc_region = 3'(r);
      @(negedge clk);
      acc_valid = 1'b0;
    end
  endtask

  task automatic run_pass(bit [NREG-1:0] hot, bit [NREG-1:0] cold, int probe, bit noise);
    int n;
    @(negedge clk);
    start = 1'b1; hot_mask = hot; cold_mask = cold;
    lk_valid = 1'b1; lk_vpn = VPN_W'(probe); lk_color = 3'd0;
    @(negedge clk);
    start = 1'b0;
    if (noise) begin acc_valid = 1'b1; acc_vpn = 12'h777; acc_region = 3'd2; end
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    acc_valid = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic check_map(int v, int orig, int exp, string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = VPN_W'(v); lk_color = 3'(orig);
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " lookup valid"}, int'(rsp_valid), 1);
    chk({tag, " lookup color"}, int'(rsp_color), exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 done after reset", int'(done), 0);
    chk("R9 acc_ready after reset", int'(acc_ready), 1);
    chk("R9 rsp_valid after reset", int'(rsp_valid), 0);
    check_map(12'h123, 4, 4, "R9 empty table");

    // Scenario A: saturation, keep-highest, cold exhaustion stop
    access(12'h100, 2, 4);               // R2 saturates at 3
    access(12'h101, 2, 1);
    access(12'h200, 5, 1);
    access(12'h201, 5, 2);
    access(12'h300, 6, 1);
    run_pass(8'b0110_0100, 8'b0000_1010, 12'h101, 1'b0);
    check_map(12'h101, 2, 1, "R4 lower-count page moved");
    check_map(12'h200, 5, 3, "R4 keep higher count");
    check_map(12'h100, 2, 2, "R4 resident stays");
    check_map(12'h300, 6, 6, "R5 stop on cold exhausted");

    // Scenario B: tie rule, decrement-then-replace, table-full stop
    access(12'h400, 0, 1);
    access(12'h401, 0, 1);
    access(12'h410, 1, 1);
    access(12'h411, 1, 1);
    access(12'h412, 1, 1);               // R2 decrement victim
    access(12'h412, 1, 1);               // R2 replace at zero
    access(12'h430, 3, 1);
    access(12'h431, 3, 1);
    run_pass(8'b0000_1011, 8'b1010_0100, 12'h412, 1'b0);
    check_map(12'h401, 0, 2, "R4 tie moves slot 1");
    check_map(12'h412, 1, 5, "R2 replaced page moved");
    check_map(12'h411, 1, 1, "R2 evicted page unmapped");
    check_map(12'h431, 3, 3, "R5 stop on full table");
    check_map(12'h400, 0, 0, "R7 miss passes color");
    check_map(12'h101, 2, 1, "R6 earlier entry kept");

    // Scenario C: budget stop
    do_reset();
    for (int r = 0; r < 5; r++) begin
      if (r != 2) begin
        access(12'h500 + 16 * r, r, 2);
        access(12'h501 + 16 * r, r, 1);
      end
    end
    run_pass(8'b0001_1011, 8'b1110_0100, 12'h511, 1'b0);
    check_map(12'h501, 0, 2, "R4 budget move one");
    check_map(12'h511, 1, 5, "R4 budget move two");
    check_map(12'h531, 3, 6, "R4 budget move three");
    check_map(12'h541, 4, 4, "R5 stop on budget");
    check_map(12'h500, 0, 0, "R7 miss after budget");

    // Scenario D: overwrite existing entry, hot masks cold, access ignored while busy
    access(12'h5F0, 2, 2);
    access(12'h501, 2, 1);
    run_pass(8'b0000_0100, 8'b1000_0100, 12'h501, 1'b1);
    check_map(12'h501, 0, 7, "R6 overwrite color");
    check_map(12'h5F0, 2, 2, "R3 hot region not cold");
    check_map(12'h777, 2, 2, "R1 busy access ignored");
    // start while busy is ignored (R3): a second strobe in the pass must not restart it
    @(negedge clk);
    start = 1'b1; hot_mask = '0; cold_mask = 8'h01;
    @(negedge clk);
    hot_mask = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 start ignored while busy", int'(busy), 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule